// File: doc/BRIEF.md
# Three-Phase Bridge Dead-Time Inserter

This block sits between a commutation or modulation stage and the gate drivers of a three-phase half-bridge. For every phase it receives an ideal "high switch on" and "low switch on" request and turns them into gate commands. These commands never drive both switches of a phase at once. Every turn-on is held back until both switches of that phase have been off for a programmable number of clock cycles.

The hold-back is asymmetric. A high-side turn-on waits for a short interval, by default 100 ns. A low-side turn-on waits for a longer interval, by default 300 ns. Both intervals are given in nanoseconds together with the clock frequency, and package functions convert them to whole cycles, rounding up, with a minimum of one cycle. Turn-off is never delayed beyond the single output register. If a request is withdrawn, moves to the other switch, or collides with its partner before the wait ends, the pending turn-on is dropped and a later request counts from zero again.

Top module: `bridge_deadtime`

## Requirements
- R1: In no phase are `top_gate_o` and `bot_gate_o` high in the same cycle.
- R2: A rise of `top_gate_o[p]` is always preceded by at least TOP_DT consecutive cycles in which both gates of phase p were low. TOP_DT is 10 at the default parameters.
- R3: A rise of `bot_gate_o[p]` is always preceded by at least BOT_DT consecutive cycles in which both gates of phase p were low. BOT_DT is 30 at the default parameters.
- R4: From a phase with both gates low, a lone request that is held steady raises its gate at the rising edge where the request has been sampled for the TOP_DT-th time (high side) or the BOT_DT-th time (low side).
- R5: When the low gate is on and the request moves to the high side, the low gate drops at the first edge that samples the change. The high gate rises exactly TOP_DT edges later.
- R6: When the high gate is on and the request moves to the low side, the high gate drops at the first edge that samples the change. The low gate rises exactly BOT_DT edges later.
- R7: A gate that is on goes low at the first rising edge that samples its request low.
- R8: If the request is withdrawn, or moves to the other switch, before the wait completes, no gate rises at that point. The next request waits the full delay of its own side, counted from its first sampling edge.
- R9: Both requests of a phase high together counts as no request. Both gates of that phase are low after the next edge, and any partial wait is discarded.
- R10: Each phase is timed on its own. Activity in one phase does not change when the gates of another phase rise or fall.
- R11: While `rst_ni` is low, all gate outputs are low whatever the requests are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all delays are counted in its cycles |
| rst_ni | input | 1 | Synchronous active-low reset |
| top_req_i | input | NUM_PHASES | Ideal high-side on request, one bit per phase |
| bot_req_i | input | NUM_PHASES | Ideal low-side on request, one bit per phase |
| top_gate_o | output | NUM_PHASES | High-side gate command after dead-time insertion |
| bot_gate_o | output | NUM_PHASES | Low-side gate command after dead-time insertion |

## Verification
The hardest situation to reach is a pending turn-on that is interrupted one cycle before it would complete. The interruption can be a withdrawal, a swap to the other switch while both gates are already low, or a collision of both requests. Uniform random stimulus almost never holds a request for 29 cycles and then breaks it at exactly the right edge. Directed sequences therefore hold a request for exactly one cycle less than the delay, then withdraw, swap or collide, and measure the restarted wait. A low-change-rate random phase adds long holds mixed with abrupt swaps, and a per-cycle reference model checks it.

// File: rtl/bdt_pkg.sv
package bdt_pkg;

  typedef enum logic [1:0] {
    SIDE_NONE = 2'd0,
    SIDE_TOP  = 2'd1,
    SIDE_BOT  = 2'd2
  } side_e;

  // Convert a delay in ns to whole clock cycles, rounding up, at least one.
  function automatic int ns_to_cycles(input int delay_ns, input int clk_mhz);
    int cyc;
    cyc = (delay_ns * clk_mhz + 999) / 1000;
    if (cyc < 1) cyc = 1;
    return cyc;
  endfunction

  // Bits needed to hold counts 0..max_count.
  function automatic int count_bits(input int max_count);
    return (max_count < 1) ? 1 : $clog2(max_count + 1);
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // A pair of requests resolves to one side; a collision counts as none.
  function automatic side_e pick_side(input logic top, input logic bot);
    if (top && !bot) return SIDE_TOP;
    if (bot && !top) return SIDE_BOT;
    return SIDE_NONE;
  endfunction

endpackage

// File: rtl/bdt_req_decode.sv
module bdt_req_decode
  import bdt_pkg::*;
(
  input  logic  top_req_i,
  input  logic  bot_req_i,
  output side_e want_o,
  output logic  collide_o
);

  assign want_o    = pick_side(top_req_i, bot_req_i);
  assign collide_o = top_req_i && bot_req_i;

endmodule

// File: rtl/bdt_turnon_timer.sv
module bdt_turnon_timer
  import bdt_pkg::*;
#(
  parameter int TOP_DT = 10,
  parameter int BOT_DT = 30,
  parameter int CW     = 5
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  idle_i,
  input  side_e want_i,
  output logic  fire_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] run;
  logic [CW-1:0] limit;
  side_e         pend_q;
  logic          counting;

  // Counting only happens while both gates are off and one side is asked for.
  assign counting = idle_i && (want_i != SIDE_NONE);

  always_comb begin
    run   = (want_i == pend_q) ? cnt_q + 1'b1 : CW'(1);
    limit = (want_i == SIDE_TOP) ? CW'(TOP_DT) : CW'(BOT_DT);
  end

  assign fire_o = counting && (run >= limit);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= SIDE_NONE;
    end else if (!counting) begin
      cnt_q  <= '0;
      pend_q <= SIDE_NONE;
    end else begin
      cnt_q  <= run;
      pend_q <= want_i;
    end
  end

  // R8: a withdrawn request leaves no partial count behind.
  p_cancel_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (want_i == SIDE_NONE) |=> (cnt_q == '0));

  // R2 / R3: the wait never runs past the longer of the two delays.
  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(cnt_q) <= max_of(TOP_DT, BOT_DT)));

endmodule

// File: rtl/bdt_phase.sv
module bdt_phase
  import bdt_pkg::*;
#(
  parameter int TOP_DT = 10,
  parameter int BOT_DT = 30,
  parameter int CW     = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic top_req_i,
  input  logic bot_req_i,
  output logic top_gate_o,
  output logic bot_gate_o
);

  localparam int MAXDT = max_of(TOP_DT, BOT_DT);

  side_e         want;
  logic          collide;
  logic          fire;
  logic          idle;
  logic          top_q, bot_q, top_d, bot_d;
  logic [CW-1:0] lowrun_q;   // consecutive both-off cycles, for the checks

  bdt_req_decode u_decode (
    .top_req_i (top_req_i),
    .bot_req_i (bot_req_i),
    .want_o    (want),
    .collide_o (collide)
  );

  assign idle = !top_q && !bot_q;

  bdt_turnon_timer #(
    .TOP_DT (TOP_DT),
    .BOT_DT (BOT_DT),
    .CW     (CW)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .idle_i (idle),
    .want_i (want),
    .fire_o (fire)
  );

  always_comb begin
    top_d = top_q;
    bot_d = bot_q;
    if (top_q) begin
      top_d = (want == SIDE_TOP);
    end else if (bot_q) begin
      bot_d = (want == SIDE_BOT);
    end else if (fire) begin
      if (want == SIDE_TOP) top_d = 1'b1;
      else                  bot_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      top_q    <= 1'b0;
      bot_q    <= 1'b0;
      lowrun_q <= '0;
    end else begin
      top_q <= top_d;
      bot_q <= bot_d;
      if (!idle)                        lowrun_q <= '0;
      else if (int'(lowrun_q) < MAXDT)  lowrun_q <= lowrun_q + 1'b1;
    end
  end

  assign top_gate_o = top_q;
  assign bot_gate_o = bot_q;

  p_exclusive_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(top_q && bot_q));

  p_top_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(top_q) |-> (int'($past(lowrun_q)) + 1 >= TOP_DT));

  p_bot_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bot_q) |-> (int'($past(lowrun_q)) + 1 >= BOT_DT));

  p_top_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (top_q && !top_req_i) |=> !top_q);

  p_bot_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bot_q && !bot_req_i) |=> !bot_q);

  p_collide_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collide |=> (!top_q && !bot_q));

endmodule

// File: rtl/bridge_deadtime.sv
module bridge_deadtime
  import bdt_pkg::*;
#(
  parameter int NUM_PHASES      = 3,
  parameter int CLK_MHZ         = 100,
  parameter int TOP_ON_DELAY_NS = 100,
  parameter int BOT_ON_DELAY_NS = 300
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PHASES-1:0] top_req_i,
  input  logic [NUM_PHASES-1:0] bot_req_i,
  output logic [NUM_PHASES-1:0] top_gate_o,
  output logic [NUM_PHASES-1:0] bot_gate_o
);

  localparam int TOP_DT = ns_to_cycles(TOP_ON_DELAY_NS, CLK_MHZ);
  localparam int BOT_DT = ns_to_cycles(BOT_ON_DELAY_NS, CLK_MHZ);
  localparam int CW     = count_bits(max_of(TOP_DT, BOT_DT));

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
    bdt_phase #(
      .TOP_DT (TOP_DT),
      .BOT_DT (BOT_DT),
      .CW     (CW)
    ) u_phase (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .top_req_i  (top_req_i[p]),
      .bot_req_i  (bot_req_i[p]),
      .top_gate_o (top_gate_o[p]),
      .bot_gate_o (bot_gate_o[p])
    );
  end

  // R11: nothing is driven on in the cycle after a reset edge.
  p_reset_quiet_r11: assert property (@(posedge clk_i)
    !rst_ni |=> (top_gate_o == '0 && bot_gate_o == '0));

endmodule

// File: tb/test_bridge_deadtime.sv
module test_bridge_deadtime;

  localparam int CLK_PERIOD = 10;
  localparam int NPH        = 3;
  localparam int MHZ        = 1000 / CLK_PERIOD;
  localparam int EXP_TOP    = (100 * MHZ + 999) / 1000;
  localparam int EXP_BOT    = (300 * MHZ + 999) / 1000;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NPH-1:0] treq = '0, breq = '0;
  logic [NPH-1:0] tgate, bgate;

  int checks = 0, errors = 0;
  bit done = 0;

  bit m_top [NPH];
  bit m_bot [NPH];
  int m_hold[NPH];
  int m_prev[NPH];

  bridge_deadtime i_bridge_deadtime (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .top_req_i  (treq),
    .bot_req_i  (breq),
    .top_gate_o (tgate),
    .bot_gate_o (bgate)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int side_of(bit t, bit b);
    if (t == b) return 0;
    return t ? 1 : 2;
  endfunction

  function automatic int wait_of(int s);
    return (s == 1) ? EXP_TOP : EXP_BOT;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    for (int p = 0; p < NPH; p++) begin
      int s;
      s = side_of(treq[p], breq[p]);
      if (!rst_n) begin
        m_top[p] = 0; m_bot[p] = 0; m_hold[p] = 0; m_prev[p] = 0;
      end else if (m_top[p] || m_bot[p]) begin
        m_top[p] = m_top[p] && (s == 1);
        m_bot[p] = m_bot[p] && (s == 2);
        m_hold[p] = 0; m_prev[p] = 0;
      end else if (s == 0) begin
        m_hold[p] = 0; m_prev[p] = 0;
      end else begin
        m_hold[p] = (s == m_prev[p]) ? m_hold[p] + 1 : 1;
        m_prev[p] = s;
        if (m_hold[p] >= wait_of(s)) begin
          if (s == 1) m_top[p] = 1; else m_bot[p] = 1;
        end
      end
    end
  endtask

  // One clock: model follows the edge, outputs compared at the falling edge.
  task automatic cycle();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    for (int p = 0; p < NPH; p++) begin
      chk("R1 exclusive gates", int'(tgate[p] & bgate[p]), 0);
      chk("R2/R3 model top gate", int'(tgate[p]), int'(m_top[p]));
      chk("R2/R3 model bottom gate", int'(bgate[p]), int'(m_bot[p]));
    end
  endtask

  task automatic measure(int p, bit want_top, output int n);
    n = 0;
    do begin
      cycle();
      n++;
    end while (((want_top ? tgate[p] : bgate[p]) == 1'b0) && n < 400);
  endtask

  task automatic go_idle();
    treq = '0; breq = '0;
    cycle();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, t1, b2;
    void'($urandom(32'h5EED_0042));
    @(negedge clk);
    // R11: requests present during reset are ignored
    treq = '1; breq = '0;
    repeat (4) cycle();
    chk("R11 reset top", int'(tgate), 0);
    chk("R11 reset bottom", int'(bgate), 0);
    treq = '0;
    rst_n = 1'b1;
    cycle();

    // R4 high side from idle, then R7 turn-off
    treq[0] = 1; measure(0, 1, n); chk("R4 top latency", n, EXP_TOP);
    treq[0] = 0; cycle(); chk("R7 top off", int'(tgate[0]), 0);
    // R4 low side from idle
    breq[0] = 1; measure(0, 0, n); chk("R4 bottom latency", n, EXP_BOT);
    // R5 low to high handover
    breq[0] = 0; treq[0] = 1; cycle();
    chk("R5 bottom released", int'(bgate[0]), 0);
    measure(0, 1, n); chk("R5 top after handover", n, EXP_TOP);
    // R6 high to low handover
    treq[0] = 0; breq[0] = 1; cycle();
    chk("R6 top released", int'(tgate[0]), 0);
    measure(0, 0, n); chk("R6 bottom after handover", n, EXP_BOT);
    breq[0] = 0; cycle(); chk("R7 bottom off", int'(bgate[0]), 0);

    // R8 withdrawal one cycle short of the wait
    go_idle();
    treq[1] = 1; repeat (EXP_TOP - 1) cycle();
    chk("R8 not yet on", int'(tgate[1]), 0);
    treq[1] = 0; cycle(); chk("R8 withdrawn", int'(tgate[1]), 0);
    treq[1] = 1; measure(1, 1, n); chk("R8 full restart", n, EXP_TOP);
    // R8 swap sides while both off
    go_idle();
    breq[2] = 1; repeat (EXP_BOT - 1) cycle();
    breq[2] = 0; treq[2] = 1; measure(2, 1, n); chk("R8 swap to top", n, EXP_TOP);
    go_idle();
    treq[2] = 1; repeat (EXP_TOP - 1) cycle();
    treq[2] = 0; breq[2] = 1; measure(2, 0, n); chk("R8 swap to bottom", n, EXP_BOT);

    // R9 collision
    go_idle();
    treq[0] = 1; breq[0] = 1; repeat (60) cycle();
    chk("R9 collide top", int'(tgate[0]), 0);
    chk("R9 collide bottom", int'(bgate[0]), 0);
    breq[0] = 0; measure(0, 1, n); chk("R9 restart after collision", n, EXP_TOP);
    breq[0] = 1; cycle();
    chk("R9 collide turns off", int'(tgate[0] | bgate[0]), 0);

    // R10 phases timed independently
    go_idle();
    treq = 3'b010; breq = 3'b100; t1 = 0; b2 = 0;
    for (int c = 1; c <= 40; c++) begin
      cycle();
      if (tgate[1] && t1 == 0) t1 = c;
      if (bgate[2] && b2 == 0) b2 = c;
      if (c == 5) breq[0] = 1;
    end
    chk("R10 phase1 top", t1, EXP_TOP);
    chk("R10 phase2 bottom", b2, EXP_BOT);
    chk("R10 phase0 bottom late", int'(bgate[0]), 1);

    // Random holds and swaps, checked against the model every cycle
    go_idle();
    for (int c = 0; c < 5000; c++) begin
      for (int p = 0; p < NPH; p++) begin
        if ($urandom_range(0, 23) == 0) begin
          int r;
          r = $urandom_range(0, 3);
          treq[p] = r[0]; breq[p] = r[1];
        end
      end
      cycle();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule